// File: doc/BRIEF.md
# Receive DMA Channel with Shared Interrupt Vectoring

This block is the receive half of a 16-bit register-mapped DMA interface. Software fills four host registers: control/status, data buffer, bus address and word count. It then sets GO. While GO is set, the channel takes bytes from an incoming stream and packs each pair into a 16-bit word, first byte in the low half. It writes every word to system memory through a bus-master write port.

Three events end a transfer: the last byte of the message, the word count reaching zero, or the bus address wrapping to zero. The count runs upward from a negative value.

The same block also forms the one interrupt request that the receive and transmit channels share. It raises the request from a set of status flags. When the host acknowledges, it latches a vector: the base for receive, base+4 for transmit, or zero when neither applies. The base vector is an input; its usual value is octal 250. The register block normally sits at octal 767600 and holds even-addressed 16-bit registers.

Top module: `rx_dma_irq`

## Requirements
- R1: After reset, the control/status, bus address, word count and data buffer registers read 0, and `irq`, `vec`, `rx_ready` and `mem_we` are 0.
- R2: Two accepted bytes form one word with the first byte in bits 7:0 and the second in bits 15:8. The word is written at address {control bits 5:4, bus address} with `mem_we` high in the cycle after the second byte is accepted. The data buffer register (select 1) then reads that word.
- R3: Each word written increments the bus address (select 2) by one and the word count (select 3) by one.
- R4: A byte accepted with `rx_last` as the first byte of a word is written at once as {8'h00, byte}.
- R5: When the byte carrying `rx_last` is accepted, end of message (control bit 13) and ready (bit 7) are set and GO (bit 0) is cleared.
- R6: When the word count steps to zero, ready (bit 7) is set and GO is cleared; later bytes are not accepted.
- R7: When the bus address steps from all ones to zero, error (bit 15) is set, GO is cleared, and end-of-message and ready are left unchanged.
- R8: Writing the control register with bit 1 set clears the bus address, the word count and any half-assembled byte. The control register takes the written value with bit 1 reading 0.
- R9: `irq` is registered and is 1 one cycle after any of these holds: `err_flag` with `int_cond` clear; `dev_ready` with `int_cond`; `host_err` with `host_err_inh` clear; `in_done` with `last_word`; `out_done`.
- R10: On a cycle with `intr_ack`, `vec` takes one of three values at the next edge. It is `vec_base` if `in_done` is set and `last_word` is clear. Otherwise it is `vec_base`+4 if `out_done` is set. Otherwise it is 0.
- R11: A control register read ORs in bit 8 = `in_done` and sets bit 7 when `dev_ready` and `in_done` are both set and GO is clear.
- R12: `rx_ready` is 0 whenever GO is clear or a register write is in progress, and no byte is accepted then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 control, 1 data buffer, 2 bus address, 3 word count |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_sel` |
| rx_valid | input | 1 | Incoming byte valid |
| rx_byte | input | 8 | Incoming byte |
| rx_last | input | 1 | Byte is the last of its message |
| rx_ready | output | 1 | Channel accepts a byte this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW+2 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| dev_ready | input | 1 | Device ready flag |
| in_done | input | 1 | Input done flag |
| out_done | input | 1 | Output done flag |
| err_flag | input | 1 | Device error flag |
| int_cond | input | 1 | Interrupt condition flag |
| host_err | input | 1 | Host error flag |
| host_err_inh | input | 1 | Inhibit interrupt on host error |
| last_word | input | 1 | Last word flag |
| vec_base | input | VW | Base interrupt vector |
| intr_ack | input | 1 | Host interrupt acknowledge |
| irq | output | 1 | Interrupt request |
| vec | output | VW | Vector latched on acknowledge |

## Verification
The packer is driven with four kinds of stream:
- An odd-length message under a nonzero upper address. It shows pairing order and the zero-padded tail, and it shows that end of message wins over a count that still has room.
- An unterminated stream with a short count. It separates count exhaustion from message end and shows the bytes left after GO drops.
- A transfer starting at the top address. It isolates the wrap error.
- A single stray byte followed by a channel reset. It shows that a half-assembled word is discarded.

The interrupt rule is tried one condition at a time, each paired with the flag that should mask it. The vector is tried with each flag combination, so that receive priority over transmit is visible.

// File: rtl/rx_dma_irq.sv
module rx_dma_irq #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int VW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_sel,
  input  logic          reg_we,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_last,
  output logic          rx_ready,
  output logic          mem_we,
  output logic [AW+1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          dev_ready,
  input  logic          in_done,
  input  logic          out_done,
  input  logic          err_flag,
  input  logic          int_cond,
  input  logic          host_err,
  input  logic          host_err_inh,
  input  logic          last_word,
  input  logic [VW-1:0] vec_base,
  input  logic          intr_ack,
  output logic          irq,
  output logic [VW-1:0] vec
);

  logic [15:0]   csr, dbuf;
  logic [AW-1:0] ba;
  logic [CW-1:0] wc;
  logic          half;
  logic [7:0]    lo;

  wire go = csr[0];
  assign rx_ready = go & ~reg_we;

  wire           take = rx_valid & rx_ready;
  wire           fire = take & (half | rx_last);
  wire [15:0]    word = half ? {rx_byte, lo} : {8'h00, rx_byte};
  wire [AW-1:0]  ba_n = ba + 1'b1;
  wire [CW-1:0]  wc_n = wc + 1'b1;

  wire irq_n = (err_flag & ~int_cond) | (dev_ready & int_cond) |
               (host_err & ~host_err_inh) | (in_done & last_word) | out_done;

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      2'd0: reg_rdata = csr | {7'b0, in_done, dev_ready & in_done & ~go, 7'b0};
      2'd1: reg_rdata = dbuf;
      2'd2: reg_rdata[AW-1:0] = ba;
      default: reg_rdata[CW-1:0] = wc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr <= '0; dbuf <= '0; ba <= '0; wc <= '0;
      half <= 1'b0; lo <= '0;
      mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      irq <= 1'b0; vec <= '0;
    end else begin
      mem_we <= fire;
      if (fire) begin
        mem_addr  <= {csr[5:4], ba};
        mem_wdata <= word;
      end
      if (reg_we) begin
        case (reg_sel)
          2'd0: begin
            csr <= reg_wdata & ~16'h0002;
            if (reg_wdata[1]) begin
              ba <= '0; wc <= '0; half <= 1'b0;
            end
          end
          2'd1: dbuf <= reg_wdata;
          2'd2: ba <= reg_wdata[AW-1:0];
          default: wc <= reg_wdata[CW-1:0];
        endcase
      end else if (take) begin
        if (!fire) begin
          lo   <= rx_byte;
          half <= 1'b1;
        end else begin
          half <= 1'b0;
          dbuf <= word;
          ba   <= ba_n;
          wc   <= wc_n;
          if (ba_n == '0) begin
            csr[15] <= 1'b1;
            csr[0]  <= 1'b0;
          end else begin
            if (rx_last) begin
              csr[13] <= 1'b1;
              csr[7]  <= 1'b1;
              csr[0]  <= 1'b0;
            end
            if (wc_n == '0) begin
              csr[7] <= 1'b1;
              csr[0] <= 1'b0;
            end
          end
        end
      end
      irq <= irq_n;
      if (intr_ack) begin
        if (in_done && !last_word) vec <= vec_base;
        else if (out_done)         vec <= vec_base + VW'(4);
        else                       vec <= '0;
      end
    end
  end

  // R2
  word_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(rx_valid && rx_ready));

  // R3
  wc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> wc == $past(wc) + 1'b1);

  // R7
  wrap_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ba == '1) |=> (csr[15] && !csr[0]));

  // R9
  irq_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> irq);

  // R10
  vec_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_ack && in_done && !last_word) |=> vec == $past(vec_base));

  // R12
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(csr[0]));

endmodule

// File: tb/rx_dma_irq_bench.sv
module rx_dma_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_last = 1'b0;
  logic        rx_ready;
  logic        mem_we;
  logic [17:0] mem_addr;
  logic [15:0] mem_wdata;
  logic dev_ready = 0, in_done = 0, out_done = 0, err_flag = 0;
  logic int_cond = 0, host_err = 0, host_err_inh = 0, last_word = 0;
  logic [8:0]  vec_base = 9'o250;
  logic        intr_ack = 1'b0;
  logic        irq;
  logic [8:0]  vec;

  int n_chk = 0, n_fail = 0;
  logic [17:0] exp_addr[$];
  logic [15:0] exp_data[$];

  always #2 clk = ~clk;

  rx_dma_irq u_rx_dma_irq (
    .clk, .rst_n, .reg_sel, .reg_we, .reg_wdata, .reg_rdata,
    .rx_valid, .rx_byte, .rx_last, .rx_ready,
    .mem_we, .mem_addr, .mem_wdata,
    .dev_ready, .in_done, .out_done, .err_flag, .int_cond,
    .host_err, .host_err_inh, .last_word,
    .vec_base, .intr_ack, .irq, .vec
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_addr.size() == 0) begin
        chk("R2 unexpected write addr", {14'b0, mem_addr}, 32'hFFFF_FFFF);
      end else begin
        chk("R2 write addr", {14'b0, mem_addr}, {14'b0, exp_addr.pop_front()});
        chk("R2/R4 write data", {16'b0, mem_wdata}, {16'b0, exp_data.pop_front()});
      end
    end
  end

  task automatic expect_word(input logic [17:0] a, input logic [15:0] d);
    exp_addr.push_back(a);
    exp_data.push_back(d);
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic send(input logic [7:0] b, input logic last);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b; rx_last = last;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_st(input logic [7:0] s);
    {dev_ready, in_done, out_done, err_flag, int_cond, host_err, host_err_inh, last_word} = s;
  endtask

  task automatic irq_case(input logic [7:0] s, input logic e, input string tag);
    @(negedge clk);
    set_st(s);
    @(negedge clk);
    chk(tag, {31'b0, irq}, {31'b0, e});
  endtask

  task automatic vec_case(input logic [7:0] s, input logic [8:0] e, input string tag);
    @(negedge clk);
    set_st(s); intr_ack = 1'b1;
    @(negedge clk);
    intr_ack = 1'b0;
    chk(tag, {23'b0, vec}, {23'b0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, d); chk("R1 csr", d, 0);
    rd(1, d); chk("R1 dbuf", d, 0);
    rd(2, d); chk("R1 ba", d, 0);
    rd(3, d); chk("R1 wc", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 vec", vec, 0);
    chk("R1 rx_ready", rx_ready, 0);

    // R12 bytes ignored while GO clear
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'h99;
    repeat (3) begin
      @(negedge clk);
      chk("R12 rx_ready idle", rx_ready, 0);
    end
    rx_valid = 1'b0;
    rd(2, d); chk("R12 ba untouched", d, 0);

    // R2 R3 R4 R5: odd message, upper address 2
    wr(2, 16'h0100);
    wr(3, 16'hFFF0);
    expect_word(18'h20100, 16'h2211);
    expect_word(18'h20101, 16'h4433);
    expect_word(18'h20102, 16'h0055);
    wr(0, 16'h0021);
    send(8'h11, 0); send(8'h22, 0); send(8'h33, 0); send(8'h44, 0); send(8'h55, 1);
    idle();
    chk("R2 all words seen", exp_addr.size(), 0);
    rd(0, d); chk("R5 csr after message end", d, 16'h20A0);
    rd(2, d); chk("R3 ba", d, 16'h0103);
    rd(3, d); chk("R3 wc", d, 16'hFFF3);
    rd(1, d); chk("R4 dbuf last word", d, 16'h0055);

    // R8 reset bit
    wr(0, 16'h0002);
    rd(0, d); chk("R8 csr after reset bit", d, 0);
    rd(2, d); chk("R8 ba cleared", d, 0);
    rd(3, d); chk("R8 wc cleared", d, 0);

    // R6 word count to zero
    wr(2, 16'h0200);
    wr(3, 16'hFFFE);
    expect_word(18'h00200, 16'hA2A1);
    expect_word(18'h00201, 16'hA4A3);
    wr(0, 16'h0001);
    send(8'hA1, 0); send(8'hA2, 0); send(8'hA3, 0); send(8'hA4, 0);
    @(negedge clk);
    rx_byte = 8'hA5;
    repeat (3) begin
      @(negedge clk);
      chk("R6 rx_ready after count zero", rx_ready, 0);
    end
    idle();
    chk("R6 all words seen", exp_addr.size(), 0);
    rd(0, d); chk("R6 csr ready", d, 16'h0080);
    rd(3, d); chk("R6 wc zero", d, 0);

    // R7 address wrap
    wr(0, 16'h0002);
    wr(2, 16'hFFFF);
    expect_word(18'h0FFFF, 16'hA55A);
    wr(0, 16'h0001);
    send(8'h5A, 0); send(8'hA5, 0);
    idle();
    rd(0, d); chk("R7 csr error", d, 16'h8000);
    rd(2, d); chk("R7 ba wrapped", d, 0);
    rd(3, d); chk("R7 wc", d, 16'h0001);
    rd(1, d); chk("R2 dbuf", d, 16'hA55A);

    // R8 pending half-word discarded
    wr(0, 16'h0002);
    wr(2, 16'h0300);
    wr(0, 16'h0001);
    send(8'h77, 0);
    idle();
    wr(0, 16'h0002);
    wr(2, 16'h0300);
    expect_word(18'h00300, 16'h0201);
    wr(0, 16'h0001);
    send(8'h01, 0); send(8'h02, 1);
    idle();
    chk("R8 pending byte dropped", exp_addr.size(), 0);

    // R11 readback flags
    wr(0, 16'h0002);
    @(negedge clk); set_st(8'b1100_0000);
    rd(0, d); chk("R11 ready+full", d, 16'h0180);
    @(negedge clk); set_st(8'b0100_0000);
    rd(0, d); chk("R11 full only", d, 16'h0100);
    wr(0, 16'h0001);
    @(negedge clk); set_st(8'b1100_0000);
    rd(0, d); chk("R11 go masks ready", d, 16'h0101);
    wr(0, 16'h0002);

    // R9 interrupt rule; order: dev_ready,in_done,out_done,err,int_cond,host_err,inh,last_word
    irq_case(8'b0000_0000, 0, "R9 none");
    @(negedge clk); set_st(8'b0010_0000);
    #1 chk("R9 not yet", irq, 0);
    @(negedge clk); chk("R9 out_done", irq, 1);
    irq_case(8'b0001_0000, 1, "R9 err no cond");
    irq_case(8'b0001_1000, 0, "R9 err with cond");
    irq_case(8'b1000_1000, 1, "R9 ready with cond");
    irq_case(8'b1000_0000, 0, "R9 ready alone");
    irq_case(8'b0000_0100, 1, "R9 host err");
    irq_case(8'b0000_0110, 0, "R9 host err inhibited");
    irq_case(8'b0100_0001, 1, "R9 done last word");
    irq_case(8'b0100_0000, 0, "R9 done alone");

    // R10 vectors
    vec_case(8'b0100_0000, 9'o250, "R10 rx vector");
    vec_case(8'b0010_0000, 9'o254, "R10 tx vector");
    vec_case(8'b0110_0001, 9'o254, "R10 last word falls to tx");
    vec_case(8'b0110_0000, 9'o250, "R10 rx before tx");
    vec_case(8'b0000_0000, 9'o000, "R10 none");
    vec_base = 9'h040;
    vec_case(8'b0010_0000, 9'h044, "R10 other base");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule